// File: doc/BRIEF.md
# Field-Masked Dual Alarm Comparator

This block watches a running BCD calendar time and raises alarms when it matches programmed values. The time comes in on one bus as seven byte fields: seconds, minutes, hours in 24-hour form, date, month, year and day of week. A once-per-second strobe marks each new value. Two independent alarms each hold seven field bytes. Bit 7 of each field byte is an enable, and bits 6:0 hold the BCD value to compare. Only the enabled fields take part in a match. An alarm can therefore repeat yearly (month and lower fields enabled), monthly (date and lower), daily (hours and lower) or weekly (day of week plus time of day).

When every enabled field of an alarm equals the current time on a strobe cycle, the block sets that alarm's sticky flag. If the alarm's interrupt enable is set, it also emits a one-cycle interrupt pulse. A flag stays set until software clears it through a masked clear write or through a read-clear pulse. The flags also appear in a status byte: alarm 0 at bit 5 and alarm 1 at bit 6. The timekeeping counter and the host bus sit outside the block. The host programs alarm bytes through a simple write port.

Top module: `dual_alarm_match`

## Requirements
- R1: While reset is high, and in the cycle after it falls, all alarm field bytes are zero and alarm_flag, alarm_irq and status_byte are all zero.
- R2: A write with cfg_we high stores cfg_data into field cfg_field (0 sec, 1 min, 2 hour, 3 date, 4 month, 5 year, 6 day of week) of alarm cfg_alarm. When a sec_tick cycle sees every enabled field matching, that alarm's flag reads 1 from the next cycle.
- R3: Only fields whose stored bit 7 is 1 are compared. The value of a field with bit 7 at 0 has no effect on the match.
- R4: Each field compares only its meaningful bits against the same bits of the time byte: bits 6:0 for seconds and minutes, 5:0 for hours and date, 4:0 for month, and 2:0 for day of week. Higher bits of the time byte, including bit 7, are ignored.
- R5: An alarm with no enabled field never sets its flag or pulses its interrupt.
- R6: A match is evaluated only in cycles with sec_tick high. A matching time without sec_tick changes nothing.
- R7: alarm_irq[i] is high for exactly the one cycle after a sec_tick cycle in which alarm i matched while int_en[i] was 1. Otherwise it is low.
- R8: A flag stays set until a cycle with rd_clr high (clears both alarms) or with clr_we high and clr_mask[i] high (clears alarm i). If a match and a clear arrive in the same cycle, the flag ends up set.
- R9: status_byte carries alarm 0's flag at bit 5 and alarm 1's flag at bit 6. All other bits read 0.
- R10: The year field never takes part in a match, even with its bit 7 set. An alarm whose only enabled field is the year never triggers.
- R11: The two alarms are independent. Writing, matching or clearing one leaves the other's flag and interrupt unaffected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sec_tick | input | 1 | One-cycle strobe marking a new time value |
| time_bus | input | 56 | BCD time; field f at bits 8f+7:8f |
| cfg_we | input | 1 | Alarm field write enable |
| cfg_alarm | input | 1 | Alarm select for the write |
| cfg_field | input | 3 | Field select for the write (0..6) |
| cfg_data | input | 8 | Field byte: bit 7 enable, bits 6:0 BCD value |
| int_en | input | 2 | Per-alarm interrupt enable |
| clr_we | input | 1 | Masked flag clear strobe |
| clr_mask | input | 2 | Flags cleared by clr_we |
| rd_clr | input | 1 | Clears both flags |
| alarm_flag | output | 2 | Sticky match flags |
| alarm_irq | output | 2 | One-cycle interrupt pulses |
| status_byte | output | 8 | Flags at bits 5 and 6 |

## Verification
The bench builds the block at its default sizes: two alarms of seven byte fields each. This puts every field position within reach, including the ignored year slot. It also covers the alarm-select bit, so a write or clear aimed at one alarm can be seen leaving the other intact. Random legal BCD times are drawn close to the programmed alarm values so that partial and full matches both occur often. Directed cases cover the masking of high bits, set-over-clear priority and alarms with no enables.

// File: rtl/alarm_cmp_pkg.sv
package alarm_cmp_pkg;
  localparam int FIELD_W    = 8;
  localparam int NUM_FIELDS = 7;
  localparam int IDX_SEC    = 0;
  localparam int IDX_MIN    = 1;
  localparam int IDX_HOUR   = 2;
  localparam int IDX_DATE   = 3;
  localparam int IDX_MONTH  = 4;
  localparam int IDX_YEAR   = 5;
  localparam int IDX_DOW    = 6;
  localparam int STS_BASE   = 5;

  // Meaningful BCD bits of each field (bit 7 is never a value bit).
  function automatic logic [FIELD_W-1:0] field_mask(input int idx);
    case (idx)
      IDX_SEC, IDX_MIN, IDX_YEAR: field_mask = 8'h7F;
      IDX_HOUR, IDX_DATE:         field_mask = 8'h3F;
      IDX_MONTH:                  field_mask = 8'h1F;
      IDX_DOW:                    field_mask = 8'h07;
      default:                    field_mask = 8'h00;
    endcase
  endfunction

  // Whether a field can take part in a match at all.
  function automatic bit field_usable(input int idx);
    field_usable = (idx != IDX_YEAR) && (idx < NUM_FIELDS);
  endfunction
endpackage

// File: rtl/alarm_regfile.sv
module alarm_regfile
  import alarm_cmp_pkg::*;
#(
  parameter int NUM_ALARMS = 2,
  parameter int NFIELDS    = NUM_FIELDS,
  localparam int AW        = (NUM_ALARMS > 1) ? $clog2(NUM_ALARMS) : 1,
  localparam int FW        = $clog2(NFIELDS),
  localparam int TOTAL_W   = NUM_ALARMS * NFIELDS * FIELD_W
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               we,
  input  logic [AW-1:0]      wr_alarm,
  input  logic [FW-1:0]      wr_field,
  input  logic [FIELD_W-1:0] wr_data,
  output logic [TOTAL_W-1:0] regs_flat
);
  logic [FIELD_W-1:0] mem [NUM_ALARMS*NFIELDS];

  always_ff @(posedge clk) begin
    for (int a = 0; a < NUM_ALARMS; a++) begin
      for (int f = 0; f < NFIELDS; f++) begin
        if (rst) begin
          mem[a*NFIELDS+f] <= '0;
        end else if (we && (wr_alarm == AW'(a)) && (wr_field == FW'(f))) begin
          mem[a*NFIELDS+f] <= wr_data;
        end
      end
    end
  end

  generate
    for (genvar g = 0; g < NUM_ALARMS*NFIELDS; g++) begin : g_flat
      assign regs_flat[g*FIELD_W +: FIELD_W] = mem[g];
    end
  endgenerate
endmodule

// File: rtl/field_cmp.sv
module field_cmp
  import alarm_cmp_pkg::*;
#(
  parameter int IDX = 0
) (
  input  logic [FIELD_W-1:0] alarm_byte,
  input  logic [FIELD_W-1:0] time_byte,
  output logic               active,
  output logic               hit
);
  localparam logic [FIELD_W-1:0] MASK   = field_mask(IDX);
  localparam bit                 USABLE = field_usable(IDX);

  logic same;

  always_comb begin
    same   = ((alarm_byte & MASK) == (time_byte & MASK));
    active = USABLE && alarm_byte[FIELD_W-1];
    hit    = !active || same;
  end
endmodule

// File: rtl/alarm_unit.sv
module alarm_unit
  import alarm_cmp_pkg::*;
#(
  parameter int NFIELDS = NUM_FIELDS,
  localparam int BUS_W  = NFIELDS * FIELD_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic [BUS_W-1:0] alarm_bytes,
  input  logic [BUS_W-1:0] time_bus,
  input  logic             int_en,
  input  logic             clr,
  output logic             flag,
  output logic             irq
);
  logic [NFIELDS-1:0] act;
  logic [NFIELDS-1:0] hit;
  logic               match;
  logic               fire;

  generate
    for (genvar f = 0; f < NFIELDS; f++) begin : g_field
      field_cmp #(.IDX(f)) u_cmp (
        .alarm_byte (alarm_bytes[f*FIELD_W +: FIELD_W]),
        .time_byte  (time_bus[f*FIELD_W +: FIELD_W]),
        .active     (act[f]),
        .hit        (hit[f])
      );
    end
  endgenerate

  always_comb begin
    match = (|act) && (&hit);
    fire  = tick && match;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      flag <= 1'b0;
      irq  <= 1'b0;
    end else begin
      flag <= fire | (flag & ~clr);
      irq  <= fire & int_en;
    end
  end
endmodule

// File: rtl/dual_alarm_match.sv
module dual_alarm_match
  import alarm_cmp_pkg::*;
#(
  parameter int NUM_ALARMS = 2,
  localparam int AW        = (NUM_ALARMS > 1) ? $clog2(NUM_ALARMS) : 1,
  localparam int FW        = $clog2(NUM_FIELDS),
  localparam int BUS_W     = NUM_FIELDS * FIELD_W
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  sec_tick,
  input  logic [BUS_W-1:0]      time_bus,
  input  logic                  cfg_we,
  input  logic [AW-1:0]         cfg_alarm,
  input  logic [FW-1:0]         cfg_field,
  input  logic [FIELD_W-1:0]    cfg_data,
  input  logic [NUM_ALARMS-1:0] int_en,
  input  logic                  clr_we,
  input  logic [NUM_ALARMS-1:0] clr_mask,
  input  logic                  rd_clr,
  output logic [NUM_ALARMS-1:0] alarm_flag,
  output logic [NUM_ALARMS-1:0] alarm_irq,
  output logic [7:0]            status_byte
);
  logic [NUM_ALARMS*BUS_W-1:0] regs_flat;
  logic [NUM_ALARMS-1:0]       clr_vec;

  alarm_regfile #(.NUM_ALARMS(NUM_ALARMS), .NFIELDS(NUM_FIELDS)) u_regs (
    .clk       (clk),
    .rst       (rst),
    .we        (cfg_we),
    .wr_alarm  (cfg_alarm),
    .wr_field  (cfg_field),
    .wr_data   (cfg_data),
    .regs_flat (regs_flat)
  );

  assign clr_vec = {NUM_ALARMS{rd_clr}} | ({NUM_ALARMS{clr_we}} & clr_mask);

  generate
    for (genvar a = 0; a < NUM_ALARMS; a++) begin : g_alarm
      alarm_unit #(.NFIELDS(NUM_FIELDS)) u_unit (
        .clk         (clk),
        .rst         (rst),
        .tick        (sec_tick),
        .alarm_bytes (regs_flat[a*BUS_W +: BUS_W]),
        .time_bus    (time_bus),
        .int_en      (int_en[a]),
        .clr         (clr_vec[a]),
        .flag        (alarm_flag[a]),
        .irq         (alarm_irq[a])
      );
    end
  endgenerate

  always_comb begin
    status_byte = '0;
    for (int a = 0; a < NUM_ALARMS; a++) begin
      if (STS_BASE + a < 8) status_byte[STS_BASE+a] = alarm_flag[a];
    end
  end
endmodule

// File: rtl/alarm_match_chk.sv
module alarm_match_chk #(
  parameter int NUM_ALARMS = 2
) (
  input logic                  clk,
  input logic                  rst,
  input logic                  sec_tick,
  input logic                  clr_we,
  input logic [NUM_ALARMS-1:0] clr_mask,
  input logic                  rd_clr,
  input logic [NUM_ALARMS-1:0] int_en,
  input logic [NUM_ALARMS-1:0] alarm_flag,
  input logic [NUM_ALARMS-1:0] alarm_irq,
  input logic [7:0]            status_byte
);
  localparam logic [7:0] USED = 8'((1 << NUM_ALARMS) - 1) << 5;

  // R9
  reserved_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (status_byte & ~USED) == 8'h00);

  generate
    for (genvar a = 0; a < NUM_ALARMS; a++) begin : g_chk
      // R6
      flag_rise_tick_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(alarm_flag[a]) |-> $past(sec_tick));
      // R7
      irq_after_tick_chk: assert property (@(posedge clk) disable iff (rst)
        alarm_irq[a] |-> ($past(sec_tick) && $past(int_en[a])));
      // R7
      irq_has_flag_chk: assert property (@(posedge clk) disable iff (rst)
        alarm_irq[a] |-> alarm_flag[a]);
      // R8
      flag_fall_clear_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(alarm_flag[a]) |-> $past(rd_clr || (clr_we && clr_mask[a])));
      // R9
      status_mirror_chk: assert property (@(posedge clk) disable iff (rst)
        status_byte[5+a] == alarm_flag[a]);
    end
  endgenerate
endmodule

bind dual_alarm_match alarm_match_chk #(.NUM_ALARMS(NUM_ALARMS)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .sec_tick    (sec_tick),
  .clr_we      (clr_we),
  .clr_mask    (clr_mask),
  .rd_clr      (rd_clr),
  .int_en      (int_en),
  .alarm_flag  (alarm_flag),
  .alarm_irq   (alarm_irq),
  .status_byte (status_byte)
);

// File: tb/tb_dual_alarm_match.sv
module tb_dual_alarm_match;
  logic        clk = 1'b0;
  logic        rst;
  logic        sec_tick;
  logic [55:0] time_bus;
  logic        cfg_we;
  logic [0:0]  cfg_alarm;
  logic [2:0]  cfg_field;
  logic [7:0]  cfg_data;
  logic [1:0]  int_en;
  logic        clr_we;
  logic [1:0]  clr_mask;
  logic        rd_clr;
  logic [1:0]  alarm_flag;
  logic [1:0]  alarm_irq;
  logic [7:0]  status_byte;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  logic [7:0] am [2][7];
  logic [7:0] tm [7];
  logic [1:0] ef;
  logic [1:0] ei;

  always #2 clk = ~clk;

  dual_alarm_match dut (
    .clk(clk), .rst(rst), .sec_tick(sec_tick), .time_bus(time_bus),
    .cfg_we(cfg_we), .cfg_alarm(cfg_alarm), .cfg_field(cfg_field), .cfg_data(cfg_data),
    .int_en(int_en), .clr_we(clr_we), .clr_mask(clr_mask), .rd_clr(rd_clr),
    .alarm_flag(alarm_flag), .alarm_irq(alarm_irq), .status_byte(status_byte)
  );

  function automatic logic [7:0] msk(input int f);
    case (f)
      0, 1, 5: msk = 8'h7F;
      2, 3:    msk = 8'h3F;
      4:       msk = 8'h1F;
      default: msk = 8'h07;
    endcase
  endfunction

  function automatic bit exp_match(input int a);
    bit any = 0;
    bit ok = 1;
    for (int f = 0; f < 7; f++) begin
      if (f != 5 && am[a][f][7]) begin
        any = 1;
        if ((am[a][f] & msk(f)) != (tm[f] & msk(f))) ok = 0;
      end
    end
    return any && ok;
  endfunction

  function automatic logic [7:0] bcd(input int lo, input int hi);
    int v = $urandom_range(hi, lo);
    return 8'(((v / 10) << 4) | (v % 10));
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input int f, input logic [7:0] d);
    cfg_we = 1; cfg_alarm = 1'(a); cfg_field = 3'(f); cfg_data = d;
    @(posedge clk); #1;
    am[a][f] = d;
    cfg_we = 0;
  endtask

  task automatic load_time();
    for (int f = 0; f < 7; f++) time_bus[f*8 +: 8] = tm[f];
  endtask

  // One cycle of stimulus, then compare at the next sample point.
  task automatic step(input string req, input bit tk, input bit cw,
                      input logic [1:0] cm, input bit rc);
    logic [1:0] fire;
    logic [1:0] clr;
    load_time();
    sec_tick = tk; clr_we = cw; clr_mask = cm; rd_clr = rc;
    for (int a = 0; a < 2; a++) fire[a] = tk && exp_match(a);
    clr = {2{rc}} | ({2{cw}} & cm);
    @(posedge clk); #1;
    ef = fire | (ef & ~clr);
    ei = fire & int_en;
    sec_tick = 0; clr_we = 0; clr_mask = 0; rd_clr = 0;
    chk({req, " flag"}, 32'(alarm_flag), 32'(ef));
    chk({req, " irq"}, 32'(alarm_irq), 32'(ei));
    chk({req, " status"}, 32'(status_byte), 32'({1'b0, ef, 5'b0}));
  endtask

  initial begin
    #(4 * 200000);
    errors++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_0A1A));
    rst = 1; sec_tick = 0; time_bus = '0; cfg_we = 0; cfg_alarm = 0; cfg_field = 0;
    cfg_data = 0; int_en = 0; clr_we = 0; clr_mask = 0; rd_clr = 0;
    for (int a = 0; a < 2; a++) for (int f = 0; f < 7; f++) am[a][f] = 8'h00;
    for (int f = 0; f < 7; f++) tm[f] = 8'h00;
    ef = 0; ei = 0;
    repeat (3) @(posedge clk);
    #1;
    // R1 reset state
    chk("R1 flag", 32'(alarm_flag), 0);
    chk("R1 irq", 32'(alarm_irq), 0);
    chk("R1 status", 32'(status_byte), 0);
    rst = 0;
    @(posedge clk); #1;
    // R1 / R5: zero registers, no enables, time all zero -> nothing
    step("R1 R5 cleared regs", 1, 0, 0, 0);

    // R2 yearly alarm on alarm 0: 12-25 07:30:15
    int_en = 2'b01;
    wr(0, 0, 8'h95); wr(0, 1, 8'hB0); wr(0, 2, 8'h87); wr(0, 3, 8'hA5); wr(0, 4, 8'h92);
    tm = '{8'h15, 8'h30, 8'h07, 8'h25, 8'h12, 8'h24, 8'h03};
    step("R6 no tick", 0, 0, 0, 0);
    step("R2 R7 R9 yearly match", 1, 0, 0, 0);
    step("R7 irq one cycle", 0, 0, 0, 0);
    tm[4] = 8'h11;
    step("R3 month differs", 1, 0, 0, 0);
    step("R11 clear other alarm", 0, 1, 2'b10, 0);
    step("R8 masked clear", 0, 1, 2'b01, 0);
    // R4 high bits of time bytes ignored
    tm = '{8'h95, 8'hB0, 8'hC7, 8'hE5, 8'hF2, 8'h99, 8'h83};
    step("R4 high bits ignored", 1, 0, 0, 0);
    // R8 set wins over same-cycle clear
    step("R8 set over clear", 1, 0, 0, 1);
    step("R8 read clear", 0, 0, 0, 1);
    // R10 year-only enable never fires
    wr(1, 5, 8'h80 | 8'h24);
    tm = '{8'h00, 8'h00, 8'h00, 8'h01, 8'h01, 8'h24, 8'h00};
    step("R10 year only", 1, 0, 0, 0);
    // R3 seconds-only alarm 1, irq off (R7)
    int_en = 2'b01;
    wr(1, 0, 8'hC2); wr(1, 1, 8'h17);
    tm = '{8'h42, 8'h05, 8'h01, 8'h02, 8'h03, 8'h10, 8'h04};
    step("R3 R7 sec only no irq", 1, 0, 0, 0);
    tm[1] = 8'h59; tm[5] = 8'h77;
    int_en = 2'b11;
    step("R3 R10 other minute", 1, 0, 0, 0);
    // R9 both flags
    tm = '{8'h15, 8'h30, 8'h07, 8'h25, 8'h12, 8'h01, 8'h00};
    wr(1, 0, 8'h95);
    step("R9 R11 both set", 1, 0, 0, 0);
    step("R8 clear both", 0, 0, 0, 1);
    // R2 weekly alarm via day of week on alarm 1
    wr(1, 0, 8'h80); wr(1, 1, 8'h80); wr(1, 2, 8'h80); wr(1, 6, 8'h83);
    tm = '{8'h00, 8'h00, 8'h00, 8'h09, 8'h06, 8'h31, 8'h03};
    step("R2 weekly", 1, 0, 0, 0);

    // Random phase
    for (int i = 0; i < 3000; i++) begin
      if ($urandom_range(15, 0) == 0) begin
        int a = $urandom_range(1, 0);
        int f = $urandom_range(6, 0);
        logic [7:0] v;
        case (f)
          0, 1: v = bcd(0, 59);
          2: v = bcd(0, 23);
          3: v = bcd(1, 31);
          4: v = bcd(1, 12);
          5: v = bcd(0, 99);
          default: v = bcd(0, 6);
        endcase
        if (f != 5) v[7] = ($urandom_range(1, 0) == 1);
        wr(a, f, v);
      end
      tm = '{bcd(0, 59), bcd(0, 59), bcd(0, 23), bcd(1, 31), bcd(1, 12), bcd(0, 99), bcd(0, 6)};
      if ($urandom_range(1, 0) == 1) begin
        int a = $urandom_range(1, 0);
        for (int f = 0; f < 7; f++)
          if ($urandom_range(5, 0) != 0 && f != 5) tm[f] = {tm[f][7], am[a][f][6:0]};
      end
      for (int f = 0; f < 7; f++) if ($urandom_range(7, 0) == 0) tm[f][7] = 1'b1;
      int_en = 2'($urandom_range(3, 0));
      step("R2 R3 R7 R8 random", $urandom_range(3, 0) != 0, $urandom_range(7, 0) == 0,
           2'($urandom_range(3, 0)), $urandom_range(15, 0) == 0);
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    done = 1;
    $finish;
  end
endmodule